// File: doc/BRIEF.md
# Symbol Port Test Path Selector

This block is the diagnostic datapath crossbar of a two-port media converter that joins a fiber port and a copper port at the level of 5-bit code-group symbols. In normal operation it forwards symbols recovered from the fiber receiver to the copper transmitter, and symbols recovered from the copper receiver to the fiber transmitter. A 2-bit test mode can instead connect an external 5-bit symbol port to one side. The external transmit input (TXD) feeds one port's transmitter, and the external receive output (RXD) carries one port's received symbols. Each port also has a symbol-level loopback that returns its own transmit symbols into its own receive path.

The copper side scrambles symbols on transmit and descrambles them on receive. Each direction XORs a local 5-bit-per-cycle keystream into the symbols. A bypass control turns both operations off. All controls are sampled while reset is held and are frozen once reset is released. Clock generation is not part of the block: the choice of clock source for the external port is given on two select outputs, and all data logic runs on one clock. RXD is registered on the rising edge and presented to the pins on the following falling edge.

Top module: `symbol_test_mux`

## Requirements
- R1: The mode, both loopback bits and the bypass bit are captured on every rising edge while `rst` is 1, and are held after `rst` falls. Later changes on those pins have no effect on any output until the next reset.
- R2: Mode 00 (normal): `cu_tx_sym_o` carries the effective fiber receive symbol, and `fib_tx_sym_o` carries the effective copper receive symbol. Each appears one rising edge after its input. `ext_rxd_o` is 00000.
- R3: Mode 10: the copper transmitter takes `ext_txd_i` and `ext_rxd_o` carries the effective copper receive symbol. `fib_tx_sym_o` sends Idle (11111). Both clock selects are 0, where 0 means the copper clock.
- R4: Mode 01: the fiber transmitter takes `ext_txd_i` and `ext_rxd_o` carries the effective fiber receive symbol. The copper transmitter sends Idle, subject to R6. Both clock selects are 1, where 1 means the fiber clock.
- R5: Mode 11: the copper transmitter takes `ext_txd_i` and `ext_rxd_o` carries the effective fiber receive symbol. `fib_tx_sym_o` sends Idle. `txclk_sel_o` is 0 and `rxclk_sel_o` is 1.
- R6: With bypass 0, the copper transmit symbol is XORed with keystream K(SEED_SCR, n), and the copper receive symbol is XORed with K(SEED_DSC, n). Here n counts the rising edges since reset was released, with n = 0 at the first one. Each keystream comes from an 11-bit register s that starts at its seed. For each symbol bit j, from 0 to 4, the register computes b = s[10] xor s[8], sets bit j to b, and shifts b in as s = {s[9:0], b}. The register advances one symbol per edge. With bypass 1, neither XOR is applied. The defaults are SEED_SCR = 11'h7FF and SEED_DSC = 11'h5A5.
- R7: With fiber loopback 1, the effective fiber receive symbol is the value `fib_tx_sym_o` had before the edge, and `fib_rx_sym_i` is ignored. With loopback 0, the effective fiber receive symbol is `fib_rx_sym_i`.
- R8: With copper loopback 1, the effective copper receive symbol is the unscrambled copper transmit symbol registered on the previous edge, whatever the bypass setting, and `cu_rx_sym_i` is ignored. With loopback 0, it is `cu_rx_sym_i` after the descrambler.
- R9: While reset is applied, both transmit outputs are Idle (11111), `ext_rxd_o` is 00000, and the loopback history is Idle.
- R10: `ext_rxd_o` changes only on the falling edge of `clk`. It presents the value registered at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset; controls are captured while it is high |
| cfg_mode_i | input | 2 | Test mode: 00 normal, 01 fiber test, 10 copper test, 11 split |
| cfg_lpbk_fib_i | input | 1 | Fiber symbol loopback request |
| cfg_lpbk_cu_i | input | 1 | Copper symbol loopback request |
| cfg_scr_bypass_i | input | 1 | 1 disables the copper scrambler and descrambler |
| fib_rx_sym_i | input | 5 | Symbol from the fiber deserializer |
| cu_rx_sym_i | input | 5 | Scrambled symbol from the copper deserializer |
| ext_txd_i | input | 5 | External test transmit symbol |
| fib_tx_sym_o | output | 5 | Symbol to the fiber serializer |
| cu_tx_sym_o | output | 5 | Symbol to the copper serializer, scrambled unless bypassed |
| ext_rxd_o | output | 5 | External test receive symbol, updated on falling edges |
| txclk_sel_o | output | 1 | Transmit clock source for the external port: 0 copper, 1 fiber |
| rxclk_sel_o | output | 1 | Receive clock source for the external port: 0 copper, 1 fiber |

## Verification
The assertions assume that the symbol inputs are synchronous to `clk`. They also assume that reset is held across at least one rising edge before any checked cycle, so the latched controls and the loopback history are defined. The path checks depend only on the latched controls, so they stay valid however the control pins move after reset. To exercise that, the stimulus inverts every control pin just after release. It drives data between edges and samples after the falling edge, with one extra sample just after each rising edge to see that RXD has not yet moved. The sweep covers all 32 combinations of mode, the two loopbacks and bypass, with arithmetic data patterns.

// File: rtl/symmux_pkg.sv
`timescale 1ns/1ps
package symmux_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL      = 2'b00,
    MODE_FIBER_TEST  = 2'b01,
    MODE_COPPER_TEST = 2'b10,
    MODE_SPLIT       = 2'b11
  } test_mode_e;
endpackage

// File: rtl/symmux_keystream.sv
`timescale 1ns/1ps
module symmux_keystream #(
  parameter int LFSR_W = 11,
  parameter int TAP_IDX = 8,
  parameter int SYM_W = 5,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SYM_W-1:0] key_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_nxt;
  logic [LFSR_W-1:0] walk;
  logic              fb;

  always_comb begin
    walk  = state_q;
    key_o = '0;
    fb    = 1'b0;
    for (int j = 0; j < SYM_W; j++) begin
      fb       = walk[LFSR_W-1] ^ walk[TAP_IDX];
      key_o[j] = fb;
      walk     = {walk[LFSR_W-2:0], fb};
    end
    state_nxt = walk;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_nxt;
  end

  // R6: a nonzero seed must never collapse into the all-zero lockup state
  assert_key_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/symmux_cfg_latch.sv
`timescale 1ns/1ps
module symmux_cfg_latch #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              lpbk_fib_i,
  input  logic              lpbk_cu_i,
  input  logic              bypass_i,
  output logic [MODE_W-1:0] mode_q,
  output logic              lpbk_fib_q,
  output logic              lpbk_cu_q,
  output logic              bypass_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= mode_i;
      lpbk_fib_q <= lpbk_fib_i;
      lpbk_cu_q  <= lpbk_cu_i;
      bypass_q   <= bypass_i;
    end
  end

  // R1: once out of reset the captured controls never move
  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable({mode_q, lpbk_fib_q, lpbk_cu_q, bypass_q}));
endmodule

// File: rtl/symbol_test_mux.sv
`timescale 1ns/1ps
module symbol_test_mux
  import symmux_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int LFSR_W = 11,
  parameter int TAP_IDX = 8,
  parameter logic [LFSR_W-1:0] SEED_SCR = 11'h7FF,
  parameter logic [LFSR_W-1:0] SEED_DSC = 11'h5A5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_lpbk_fib_i,
  input  logic             cfg_lpbk_cu_i,
  input  logic             cfg_scr_bypass_i,
  input  logic [SYM_W-1:0] fib_rx_sym_i,
  input  logic [SYM_W-1:0] cu_rx_sym_i,
  input  logic [SYM_W-1:0] ext_txd_i,
  output logic [SYM_W-1:0] fib_tx_sym_o,
  output logic [SYM_W-1:0] cu_tx_sym_o,
  output logic [SYM_W-1:0] ext_rxd_o,
  output logic             txclk_sel_o,
  output logic             rxclk_sel_o
);
  localparam logic [SYM_W-1:0] IDLE = '1;

  logic [1:0]       mode_q;
  logic             lpbk_fib_q, lpbk_cu_q, bypass_q;
  test_mode_e       mode;
  logic [SYM_W-1:0] key_scr, key_dsc;
  logic [SYM_W-1:0] cu_pre_q, ext_rxd_q;
  logic [SYM_W-1:0] fib_rx_eff, cu_rx_eff, cu_pre_nxt, fib_tx_nxt, rxd_nxt;

  symmux_cfg_latch #(.MODE_W(2)) u_cfg (
    .clk(clk), .rst(rst),
    .mode_i(cfg_mode_i), .lpbk_fib_i(cfg_lpbk_fib_i),
    .lpbk_cu_i(cfg_lpbk_cu_i), .bypass_i(cfg_scr_bypass_i),
    .mode_q(mode_q), .lpbk_fib_q(lpbk_fib_q),
    .lpbk_cu_q(lpbk_cu_q), .bypass_q(bypass_q)
  );

  symmux_keystream #(.LFSR_W(LFSR_W), .TAP_IDX(TAP_IDX), .SYM_W(SYM_W), .SEED(SEED_SCR))
    u_scr (.clk(clk), .rst(rst), .key_o(key_scr));

  symmux_keystream #(.LFSR_W(LFSR_W), .TAP_IDX(TAP_IDX), .SYM_W(SYM_W), .SEED(SEED_DSC))
    u_dsc (.clk(clk), .rst(rst), .key_o(key_dsc));

  assign mode = test_mode_e'(mode_q);

  // Effective receive symbols after loopback and descrambling
  always_comb begin
    fib_rx_eff = lpbk_fib_q ? fib_tx_sym_o : fib_rx_sym_i;
    if (lpbk_cu_q)     cu_rx_eff = cu_pre_q;
    else if (bypass_q) cu_rx_eff = cu_rx_sym_i;
    else               cu_rx_eff = cu_rx_sym_i ^ key_dsc;
  end

  // Crossbar selected by the latched mode
  always_comb begin
    case (mode)
      MODE_NORMAL: begin
        cu_pre_nxt = fib_rx_eff;
        fib_tx_nxt = cu_rx_eff;
        rxd_nxt    = '0;
      end
      MODE_FIBER_TEST: begin
        cu_pre_nxt = IDLE;
        fib_tx_nxt = ext_txd_i;
        rxd_nxt    = fib_rx_eff;
      end
      MODE_COPPER_TEST: begin
        cu_pre_nxt = ext_txd_i;
        fib_tx_nxt = IDLE;
        rxd_nxt    = cu_rx_eff;
      end
      default: begin
        cu_pre_nxt = ext_txd_i;
        fib_tx_nxt = IDLE;
        rxd_nxt    = fib_rx_eff;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fib_tx_sym_o <= IDLE;
      cu_tx_sym_o  <= IDLE;
      cu_pre_q     <= IDLE;
      ext_rxd_q    <= '0;
    end else begin
      fib_tx_sym_o <= fib_tx_nxt;
      cu_tx_sym_o  <= bypass_q ? cu_pre_nxt : (cu_pre_nxt ^ key_scr);
      cu_pre_q     <= cu_pre_nxt;
      ext_rxd_q    <= rxd_nxt;
    end
  end

  // External receive symbols launch on the falling edge
  always_ff @(negedge clk) begin
    if (rst) ext_rxd_o <= '0;
    else     ext_rxd_o <= ext_rxd_q;
  end

  assign txclk_sel_o = (mode == MODE_FIBER_TEST);
  assign rxclk_sel_o = mode_q[0];

  assert_normal_rxd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_NORMAL |=> ext_rxd_q == '0);

  assert_copper_test_tx_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_COPPER_TEST && bypass_q) |=> cu_tx_sym_o == $past(ext_txd_i));

  assert_fiber_test_tx_R4: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_FIBER_TEST |=> fib_tx_sym_o == $past(ext_txd_i));

  assert_split_fib_idle_R5: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_SPLIT |=> fib_tx_sym_o == IDLE);

  assert_fib_loop_rxd_R7: assert property (@(posedge clk) disable iff (rst)
    (lpbk_fib_q && mode == MODE_FIBER_TEST) |=> ext_rxd_q == $past(fib_tx_sym_o));
endmodule

// File: tb/symbol_test_mux_tb.sv
`timescale 1ns/1ps
module symbol_test_mux_tb;
  localparam logic [10:0] SEED_S = 11'h7FF;
  localparam logic [10:0] SEED_D = 11'h5A5;
  localparam logic [4:0]  IDLE   = 5'h1F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_lf = 1'b0, cfg_lc = 1'b0, cfg_bp = 1'b0;
  logic [4:0] fib_rx = '0, cu_rx = '0, txd = '0;
  logic [4:0] fib_tx, cu_tx, rxd;
  logic txsel, rxsel;

  int n_run = 0, n_fail = 0, kk = 0;
  logic [1:0] lm;
  logic lf, lc, lb;
  logic [4:0] p_cupre, p_fibtx, p_rxd;

  always #10 clk = ~clk;

  symbol_test_mux u_dut (
    .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode), .cfg_lpbk_fib_i(cfg_lf),
    .cfg_lpbk_cu_i(cfg_lc), .cfg_scr_bypass_i(cfg_bp),
    .fib_rx_sym_i(fib_rx), .cu_rx_sym_i(cu_rx), .ext_txd_i(txd),
    .fib_tx_sym_o(fib_tx), .cu_tx_sym_o(cu_tx), .ext_rxd_o(rxd),
    .txclk_sel_o(txsel), .rxclk_sel_o(rxsel)
  );

  function automatic logic [4:0] keyval(logic [10:0] seed, int n);
    logic [10:0] s = seed;
    logic [4:0] k = '0;
    logic b;
    for (int i = 0; i <= n; i++)
      for (int j = 0; j < 5; j++) begin
        b = s[10] ^ s[8];
        k[j] = b;
        s = {s[9:0], b};
      end
    return k;
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m, logic f, logic c, logic b);
    cfg_mode = m; cfg_lf = f; cfg_lc = c; cfg_bp = b;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #15;
    check("R9 fib_tx", fib_tx, IDLE);
    check("R9 cu_tx", cu_tx, IDLE);
    check("R9 ext_rxd", rxd, 5'h00);
    rst = 1'b0;
    lm = m; lf = f; lc = c; lb = b;
    // R1: flip every control pin after release; outputs must follow the latched set
    cfg_mode = ~m; cfg_lf = ~f; cfg_lc = ~c; cfg_bp = ~b;
    kk = 0; p_cupre = IDLE; p_fibtx = IDLE; p_rxd = 5'h00;
  endtask

  task automatic cyc(logic [4:0] fr, logic [4:0] cr, logic [4:0] tx);
    logic [4:0] ks, kd, cre, fre, cupre, ftx, ctx, erx;
    string mt;
    fib_rx = fr; cu_rx = cr; txd = tx;
    ks = keyval(SEED_S, kk);
    kd = keyval(SEED_D, kk);
    cre = lc ? p_cupre : (lb ? cr : cr ^ kd);
    fre = lf ? p_fibtx : fr;
    case (lm)
      2'b00: begin cupre = fre;  ftx = cre;  erx = 5'h00; mt = "R2"; end
      2'b01: begin cupre = IDLE; ftx = tx;   erx = fre;   mt = "R4"; end
      2'b10: begin cupre = tx;   ftx = IDLE; erx = cre;   mt = "R3"; end
      default: begin cupre = tx; ftx = IDLE; erx = fre;   mt = "R5"; end
    endcase
    ctx = lb ? cupre : cupre ^ ks;
    @(posedge clk);
    #2;
    check("R10 ext_rxd held until falling edge", rxd, p_rxd);
    #13;
    check($sformatf("%s R1%s fib_tx", mt, lc ? " R8" : ""), fib_tx, ftx);
    check($sformatf("%s R6 R1%s cu_tx", mt, lf ? " R7" : ""), cu_tx, ctx);
    check($sformatf("%s R1%s%s ext_rxd", mt, lf ? " R7" : "", lc ? " R8" : ""), rxd, erx);
    check($sformatf("%s clk selects", mt), {3'b000, txsel, rxsel},
          {3'b000, lm == 2'b01, lm[0]});
    p_cupre = cupre; p_fibtx = ftx; p_rxd = erx;
    kk++;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 32; c++) begin
      do_reset(c[1:0], c[2], c[3], c[4]);
      for (int i = 0; i < 8; i++)
        cyc(5'((i * 7 + c) & 31), 5'((i * 11 + 3 * c + 5) & 31), 5'((i * 13 + 5 * c + 9) & 31));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule